// File: doc/BRIEF.md
# Sector Hamming Code Checker and Corrector

This block decides what to do with a 512-byte sector after a single-error-correcting Hamming code has been worked out over it. It takes the 24-bit code computed for the data and the 24-bit code read back from the spare area, and compares them. It then returns one of four verdicts. If the data has a single flipped bit, it also returns the byte offset and the one-hot bit mask that software or a buffer engine must XOR into the sector.

The code is kept as two 12-bit halves that complement each other. When the data holds one flipped bit, the two halves of the difference XOR to all ones. The code is stored inverted, so an erased page, whose data and spare bytes all read 0xFF, checks clean.

The computed code can arrive in either of two forms. The first is the raw 32-bit word from the parity engine: the block strips the reserved bits, packs what is left and inverts it. The second is three already-formatted bytes. In both cases the packed and inverted form of the raw word is also output, so the same block can produce the bytes to write into the spare area.

Top module: `sector_ecc_check`

## Requirements
- R1: `packed_code` equals the bitwise inverse of {raw_word[27:16], raw_word[11:0]}. Byte 0 of the stored code is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16.
- R2: Raw word bits 31:28 and 15:12 have no effect on any output.
- R3: When the selected computed code equals `stored_code`, the status is 0 (clean) and both offset and mask are 0.
- R4: Let the difference be the computed code XOR the stored code. If difference[23:12] XOR difference[11:0] is 0xFFF and the offset is inside the sector, the status is 1 (data fixed). In that case the offset is difference[23:15] and the mask is 1 shifted left by difference[14:12].
- R5: If the XOR test of R4 passes but the offset is not below the SECTOR_BYTES parameter, the status is 3 (uncorrectable).
- R6: A difference with exactly one bit set gives status 2 (error in the code bytes only), with offset 0 and mask 0.
- R7: Any other nonzero difference gives status 3, with offset 0 and mask 0.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. All outputs are registered, load only when `in_valid` is high, and hold their values otherwise.
- R9: When `use_raw` is 1 the computed code is the packed word of R1; when it is 0 the computed code is `calc_code`. With `use_raw` 1, a zero raw word against stored bytes FF FF FF is clean.
- R10: While reset is high and after it is released, every output is 0 until the first valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs below are valid this cycle |
| use_raw | input | 1 | 1: computed code comes from raw_word, 0: from calc_code |
| raw_word | input | 32 | Raw result word of the parity engine |
| calc_code | input | 24 | Computed code as three little-endian bytes |
| stored_code | input | 24 | Code read from the spare area, three little-endian bytes |
| out_valid | output | 1 | Result pulse, one cycle after in_valid |
| packed_code | output | 24 | Inverted packed form of raw_word, ready to store |
| status | output | 2 | 0 clean, 1 data fixed, 2 code-only error, 3 uncorrectable |
| fix_offset | output | 9 | Byte offset in the sector to correct |
| fix_mask | output | 8 | One-hot bit mask to XOR at fix_offset |

## Verification
The assertions assume that `in_valid` is a plain single-cycle qualifier and that the inputs are stable around the clock edge. The clean-result property also assumes that, with `use_raw` low, the two codes match exactly. The stimulus drives every input on the falling edge and holds it for a full cycle. It mixes directed cases with random words in which the reserved raw bits are randomised. Correctable differences are built from a chosen offset and bit index, and single-bit differences are built from a chosen bit position. A second instance, with a sector of half the size, reaches the out-of-range case.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int BIT_W  = 3;
  localparam int OFF_W  = HALF_W - BIT_W;
  localparam int MASK_W = 1 << BIT_W;
  localparam int RAW_W  = 32;
  localparam int HI_LSB = RAW_W / 2;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_BAD      = 2'd3
  } chk_status_e;
endpackage

// File: rtl/ecc_word_pack.sv
module ecc_word_pack
  import ecc_chk_pkg::*;
(
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);
  // Keep the two parity halves, drop the reserved nibbles, invert for erased pages.
  always_comb begin
    code = ~{raw[HI_LSB +: HALF_W], raw[0 +: HALF_W]};
  end
endmodule

// File: rtl/ecc_diff_classify.sv
module ecc_diff_classify
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output chk_status_e       verdict,
  output logic [OFF_W-1:0]  offset,
  output logic [MASK_W-1:0] mask
);
  localparam logic [OFF_W:0] LIMIT = (SECTOR_BYTES >= (1 << OFF_W)) ?
                                     (OFF_W+1)'(1 << OFF_W) : (OFF_W+1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] fold;
  logic [OFF_W-1:0]  pos_byte;
  logic [BIT_W-1:0]  pos_bit;
  logic              one_bit;

  always_comb begin
    diff     = calc ^ stored;
    fold     = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
    pos_byte = diff[CODE_W-1 -: OFF_W];
    pos_bit  = diff[HALF_W +: BIT_W];
    one_bit  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
    verdict  = ST_CLEAN;
    offset   = '0;
    mask     = '0;
    if (diff == '0) begin
      verdict = ST_CLEAN;
    end else if (fold == '1) begin
      if ({1'b0, pos_byte} < LIMIT) begin
        verdict = ST_FIXED;
        offset  = pos_byte;
        mask    = MASK_W'(1) << pos_bit;
      end else begin
        verdict = ST_BAD;
      end
    end else if (one_bit) begin
      verdict = ST_CODE_ERR;
    end else begin
      verdict = ST_BAD;
    end
  end
endmodule

// File: rtl/sector_ecc_check.sv
module sector_ecc_check
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              use_raw,
  input  logic [31:0]       raw_word,
  input  logic [23:0]       calc_code,
  input  logic [23:0]       stored_code,
  output logic              out_valid,
  output logic [23:0]       packed_code,
  output logic [1:0]        status,
  output logic [8:0]        fix_offset,
  output logic [7:0]        fix_mask
);
  logic [CODE_W-1:0] pk;
  logic [CODE_W-1:0] sel_code;
  chk_status_e       verdict;
  logic [OFF_W-1:0]  offset;
  logic [MASK_W-1:0] mask;

  ecc_word_pack u_pack (
    .raw  (raw_word),
    .code (pk)
  );

  assign sel_code = use_raw ? pk : calc_code;

  ecc_diff_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .calc    (sel_code),
    .stored  (stored_code),
    .verdict (verdict),
    .offset  (offset),
    .mask    (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      packed_code <= '0;
      status      <= '0;
      fix_offset  <= '0;
      fix_mask    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        packed_code <= pk;
        status      <= verdict;
        fix_offset  <= offset;
        fix_mask    <= mask;
      end
    end
  end

  // R8: result pulse follows the input qualifier by one cycle
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4: a fix names one bit inside the sector
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && status == 2'd1) |-> ($countones(fix_mask) == 1 && fix_offset < SECTOR_BYTES));
  // R6 and R7: no location reported unless data is fixed
  p_no_loc_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && status != 2'd1) |-> (fix_mask == '0 && fix_offset == '0));
  // R3: matching formatted codes report clean
  p_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_raw && calc_code == stored_code) |=> status == 2'd0);
  // R8: outputs hold between valid inputs
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(status) && $stable(packed_code) && $stable(fix_mask)));
endmodule

// File: tb/sector_ecc_check_bench.sv
module sector_ecc_check_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        use_raw = 1'b0;
  logic [31:0] raw_word = '0;
  logic [23:0] calc_code = '0;
  logic [23:0] stored_code = '0;

  logic        out_valid, h_valid;
  logic [23:0] packed_code, h_packed;
  logic [1:0]  status, h_status;
  logic [8:0]  fix_offset, h_offset;
  logic [7:0]  fix_mask, h_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sector_ecc_check u_sector_ecc_check (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_raw(use_raw),
    .raw_word(raw_word), .calc_code(calc_code), .stored_code(stored_code),
    .out_valid(out_valid), .packed_code(packed_code), .status(status),
    .fix_offset(fix_offset), .fix_mask(fix_mask));

  sector_ecc_check #(.SECTOR_BYTES(256)) u_sector_ecc_check_half (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_raw(use_raw),
    .raw_word(raw_word), .calc_code(calc_code), .stored_code(stored_code),
    .out_valid(h_valid), .packed_code(h_packed), .status(h_status),
    .fix_offset(h_offset), .fix_mask(h_mask));

  // Reference: behavioural, integer arithmetic on the requirement text
  function automatic void model(input int unsigned raw, input int unsigned calc,
                                input int unsigned stor, input bit sel, input int sector,
                                output int unsigned pk, output int st,
                                output int off, output int msk);
    int unsigned d;
    pk = (~((((raw >> 16) & 32'hFFF) << 12) | (raw & 32'hFFF))) & 32'hFFFFFF; // R1
    d  = ((sel ? pk : calc) ^ stor) & 32'hFFFFFF;                              // R9
    off = 0; msk = 0;
    if (d == 0) st = 0;                                                         // R3
    else if ((((d >> 12) ^ d) & 32'hFFF) == 32'hFFF) begin
      if (int'(d >> 15) < sector) begin
        st = 1; off = int'(d >> 15); msk = 1 << ((d >> 12) & 7);                // R4
      end else st = 3;                                                          // R5
    end else if ((d & (d - 1)) == 0) st = 2;                                    // R6
    else st = 3;                                                                // R7
  endfunction

  bit          e_valid;
  int unsigned e_pk;
  int          e_st, e_off, e_msk, eh_st, eh_off, eh_msk;

  always @(posedge clk) begin
    int unsigned pk;
    int st, off, msk, st2, off2, msk2;
    if (rst) begin
      e_valid <= 0; e_pk <= 0; e_st <= 0; e_off <= 0; e_msk <= 0;
      eh_st <= 0; eh_off <= 0; eh_msk <= 0;
    end else begin
      e_valid <= in_valid;
      if (in_valid) begin
        model(raw_word, calc_code, stored_code, use_raw, 512, pk, st, off, msk);
        model(raw_word, calc_code, stored_code, use_raw, 256, pk, st2, off2, msk2);
        e_pk <= pk; e_st <= st; e_off <= off; e_msk <= msk;
        eh_st <= st2; eh_off <= off2; eh_msk <= msk2;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int st);
    case (st)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Compare every cycle, halfway between the rising and the falling edge
  always @(posedge clk) begin
    #5;
    if (!rst && !done) begin
      check("R8 valid", int'(out_valid), int'(e_valid));
      check("R1 packed (R2 reserved bits random)", int'(packed_code), int'(e_pk));
      check({tag_of(e_st), " status"}, int'(status), e_st);
      check({tag_of(e_st), " offset"}, int'(fix_offset), e_off);
      check({tag_of(e_st), " mask"}, int'(fix_mask), e_msk);
      check("R5 half-sector status", int'(h_status), eh_st);
      check("R5 half-sector offset", int'(h_offset), eh_off);
      check("R5 half-sector mask", int'(h_mask), eh_msk);
    end
  end

  task automatic drive(input logic [31:0] raw, input logic [23:0] calc,
                       input logic [23:0] stor, input bit sel);
    @(negedge clk);
    in_valid = 1'b1; use_raw = sel; raw_word = raw; calc_code = calc; stored_code = stor;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [23:0] fix_diff(input int off, input int b);
    logic [11:0] hi;
    hi = {off[8:0], b[2:0]};
    return {hi, ~hi};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", int'(out_valid), 0);
    check("R10 status", int'(status), 0);
    check("R10 packed", int'(packed_code), 0);
    check("R10 mask", int'(fix_mask), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", int'(out_valid), 0);

    // R9: erased page checks clean via raw path
    drive(32'h0, 24'h0, 24'hFFFFFF, 1'b1);
    // R2: reserved bits set, still clean
    drive(32'hF000_F000, 24'h0, 24'hFFFFFF, 1'b1);
    // R3: formatted path, equal codes
    drive(32'h0, 24'h5A3C96, 24'h5A3C96, 1'b0);
    // R4: correctable, first and last byte, several bits
    drive(32'h0, 24'h123456, 24'h123456 ^ fix_diff(0, 0), 1'b0);
    drive(32'h0, 24'h123456, 24'h123456 ^ fix_diff(511, 7), 1'b0);
    // R5: offset 300 fixed in full sector, out of range in half sector
    drive(32'h0, 24'hABCDEF, 24'hABCDEF ^ fix_diff(300, 3), 1'b0);
    // R6: single-bit difference, low and high halves
    drive(32'h0, 24'h000F00, 24'h000F01, 1'b0);
    drive(32'h0, 24'h000F00, 24'h800F00, 1'b0);
    // R7: two-bit difference
    drive(32'h0, 24'h0, 24'h000003, 1'b0);
    // R8: back-to-back valids
    @(negedge clk);
    in_valid = 1'b1; use_raw = 1'b0; calc_code = 24'h1; stored_code = 24'h1;
    @(negedge clk);
    calc_code = 24'h2; stored_code = 24'h7;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      logic [23:0] c, s, d;
      int k;
      r = $urandom; c = $urandom; k = $urandom_range(0, 3);
      case (k)
        0: d = 24'h0;
        1: d = fix_diff($urandom_range(0, 511), $urandom_range(0, 7));
        2: d = 24'(1) << $urandom_range(0, 23);
        default: d = 24'($urandom);
      endcase
      if (i % 2 == 0) s = (~{r[27:16], r[11:0]}) ^ d;
      else s = c ^ d;
      drive(r, c, s, (i % 2 == 0));
      if (i % 5 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule